// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block collects interrupt requests for a small 8-bit microcontroller core and turns them into subroutine calls to fixed vector addresses. There are four request inputs. A data-ready pulse and the falling edge of an active-low battery-fail pin both raise one shared request flag. A programmable-timer tick and a timer/event-counter overflow pulse each raise a flag of their own. Software sees all enables and flags in one 8-bit control/status register and can write it.

The core asserts a service strobe once per machine cycle. On a strobe cycle, the controller accepts the highest-priority request if the global enable is on, the source is enabled and its flag is set, and the hardware stack has room. Accepting a request clears that source's flag and the global enable in the same clock. One clock later the controller presents a one-cycle call request with the vector address. RETI from the core turns the global enable back on. RET leaves it alone.

The sequencer has two states. In `ST_IDLE` it waits; the transition "accept" goes to `ST_ISSUE` when a request is taken. `ST_ISSUE` drives the call and always takes the transition "done" back to `ST_IDLE` on the next clock.

Top module: `vic_top`

## Requirements
- R1: After reset the register reads 0x00, `call_req` is 0 and `vec_addr` is 0.
- R2: The register layout is: bit0 global enable, bit1 shared data-ready/battery-fail enable, bit2 timer enable, bit3 counter enable, bit4 shared flag, bit5 timer flag, bit6 counter flag. Bit7 always reads 0. A write loads bits 6:0 at the next clock.
- R3: A clock with `rdy_pulse` high sets bit4, a clock with `tick_pulse` high sets bit5, and a clock with `ovf_pulse` high sets bit6. Each is visible after that clock.
- R4: A high-to-low transition of `batt_n` sets bit4. Holding `batt_n` low or raising it sets nothing.
- R5: A request is accepted only in a clock with `svc_stb` high, global enable 1, `stk_full` 0 and at least one source whose enable and flag are both 1.
- R6: The vectors are 0x04 (shared data-ready/battery-fail), 0x08 (timer) and 0x0C (counter). Simultaneous ready sources are taken in that order.
- R7: Acceptance clears the serviced flag and the global enable. Flags of other sources stay set.
- R8: `call_req` is high for exactly one clock after each acceptance, with `vec_addr` holding the vector. Otherwise `call_req` is 0 and `vec_addr` is 0. No request is accepted in the clock in which `call_req` is high.
- R9: `reti_stb` sets the global enable, even over a write of 0 in the same clock. `ret_stb` changes nothing.
- R10: A hardware flag set wins over a software write clearing that flag, and over an acceptance clearing it, in the same clock.
- R11: A software write that sets the global enable during a service routine allows a further (nested) acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| rdy_pulse | input | 1 | Data-ready request pulse |
| batt_n | input | 1 | Battery-fail pin, falling edge requests |
| tick_pulse | input | 1 | Programmable-timer tick |
| ovf_pulse | input | 1 | Timer/event-counter overflow pulse |
| stk_full | input | 1 | Hardware stack full |
| svc_stb | input | 1 | Once-per-machine-cycle service strobe |
| ret_stb | input | 1 | RET executed |
| reti_stb | input | 1 | RETI executed |
| call_req | output | 1 | Call request, one clock per acceptance |
| vec_addr | output | 8 | Vector address during call_req |

## Verification
Requests are raised singly, so each flag bit and each vector is tested on its own. Then all three are raised at once, so the order of acceptance shows the priority and shows that the flags not yet serviced are kept. Acceptance is tried with each gating input taken away in turn: no strobe, global enable off, stack full. The battery-fail pin is held low and then released, which separates edge sensing from level sensing. Coincident write/set and accept/set clocks check the precedence rules. RET against RETI and a software re-enable during a service routine check the return and nesting paths.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } vic_state_e;

    localparam int NSRC   = 3;
    localparam int BIT_GE = 0;
    localparam int BIT_EN = 1;
    localparam int BIT_FL = 4;
endpackage

// File: rtl/vic_edge.sv
module vic_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_n;
    end

    assign fall = pin_q & ~pin_n;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) grant = N'(1) << i;
        end
    end

    assign any = |req;
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int AW    = 8,
    parameter int VBASE = 4,
    parameter int VSTEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          rdy_pulse,
    input  logic          batt_n,
    input  logic          tick_pulse,
    input  logic          ovf_pulse,
    input  logic          stk_full,
    input  logic          svc_stb,
    input  logic          ret_stb,
    input  logic          reti_stb,
    output logic          call_req,
    output logic [AW-1:0] vec_addr
);
    import vic_pkg::*;

    vic_state_e       st_q, st_d;
    logic             gie_q, gie_d;
    logic [NSRC-1:0]  en_q, en_d, flg_q, flg_d;
    logic [AW-1:0]    vec_q, vec_d;
    logic             bf_fall;
    logic [NSRC-1:0]  hw_set, ready, grant;
    logic             any_ready, take;
    logic             unused_ret;

    // RET has no effect on controller state
    assign unused_ret = ret_stb;

    vic_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (batt_n),
        .fall  (bf_fall)
    );

    assign hw_set = {ovf_pulse, tick_pulse, rdy_pulse | bf_fall};
    assign ready  = en_q & flg_q;

    vic_prio #(.N(NSRC)) u_prio (
        .req   (ready),
        .grant (grant),
        .any   (any_ready)
    );

    assign take = (st_q == ST_IDLE) && svc_stb && gie_q && !stk_full && any_ready;

    // next-state logic of the sequencer
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (take) st_d = ST_ISSUE;   // accept
            ST_ISSUE: st_d = ST_IDLE;              // done
            default:  st_d = ST_IDLE;
        endcase
    end

    // vector of the granted source
    always_comb begin
        vec_d = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) vec_d = AW'(VBASE + i * VSTEP);
        end
    end

    // register next value: write, then RETI, then acceptance, then hardware set
    always_comb begin
        gie_d = reg_wr ? reg_wdata[BIT_GE] : gie_q;
        en_d  = reg_wr ? reg_wdata[BIT_EN +: NSRC] : en_q;
        flg_d = reg_wr ? reg_wdata[BIT_FL +: NSRC] : flg_q;
        if (reti_stb) gie_d = 1'b1;
        if (take) begin
            gie_d = 1'b0;
            flg_d = flg_d & ~grant;
        end
        flg_d = flg_d | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            gie_q <= 1'b0;
            en_q  <= '0;
            flg_q <= '0;
            vec_q <= '0;
        end else begin
            st_q  <= st_d;
            gie_q <= gie_d;
            en_q  <= en_d;
            flg_q <= flg_d;
            if (take) vec_q <= vec_d;
        end
    end

    // outputs
    always_comb begin
        call_req  = (st_q == ST_ISSUE);
        vec_addr  = call_req ? vec_q : '0;
        reg_rdata = {1'b0, flg_q, en_q, gie_q};
    end
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
    parameter int AW    = 8,
    parameter int VBASE = 4,
    parameter int VSTEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reti_stb,
    input logic          tick_pulse,
    input logic          svc_stb,
    input logic          stk_full,
    input logic          call_req,
    input logic [AW-1:0] vec_addr,
    input logic [7:0]    reg_rdata
);
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> !call_req);

    a_r8_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req |-> vec_addr == '0);

    a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> $past(svc_stb && !stk_full && reg_rdata[0]));

    a_r7_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !reg_rdata[0]);

    a_r6_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (vec_addr == AW'(VBASE) || vec_addr == AW'(VBASE + VSTEP)
                      || vec_addr == AW'(VBASE + 2 * VSTEP)));

    a_r3_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> reg_rdata[5]);

    a_r9_reti_on: assert property (@(posedge clk) disable iff (!rst_n)
        reti_stb |=> (reg_rdata[0] || call_req));
endmodule

bind vic_top vic_top_chk #(.AW(AW), .VBASE(VBASE), .VSTEP(VSTEP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reti_stb   (reti_stb),
    .tick_pulse (tick_pulse),
    .svc_stb    (svc_stb),
    .stk_full   (stk_full),
    .call_req   (call_req),
    .vec_addr   (vec_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/vic_top_tb.sv
module vic_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, rdy_pulse = 0, batt_n = 1, tick_pulse = 0, ovf_pulse = 0;
    logic       stk_full = 0, svc_stb = 0, ret_stb = 0, reti_stb = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata, vec_addr;
    logic       call_req;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int m_gie = 0, m_en = 0, m_flg = 0, m_call = 0, m_vec = 0, m_bq = 1;

    always #2.5 clk = ~clk;

    vic_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rdy_pulse(rdy_pulse), .batt_n(batt_n),
        .tick_pulse(tick_pulse), .ovf_pulse(ovf_pulse), .stk_full(stk_full),
        .svc_stb(svc_stb), .ret_stb(ret_stb), .reti_stb(reti_stb),
        .call_req(call_req), .vec_addr(vec_addr)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural model, one step per clock
    always @(posedge clk) begin
        int ng, ne, nf, rdy, fall, pick, vec;
        if (!rst_n) begin
            m_gie = 0; m_en = 0; m_flg = 0; m_call = 0; m_vec = 0; m_bq = 1;
        end else begin
            fall = (m_bq == 1 && batt_n == 0) ? 1 : 0;
            m_bq = batt_n;
            rdy  = m_en & m_flg;
            pick = 0; vec = 0;
            if (m_call == 0 && svc_stb && m_gie == 1 && !stk_full && rdy != 0) begin
                if (rdy % 2 == 1)            begin pick = 1; vec = 'h04; end
                else if ((rdy / 2) % 2 == 1) begin pick = 2; vec = 'h08; end
                else                         begin pick = 4; vec = 'h0C; end
            end
            ng = m_gie; ne = m_en; nf = m_flg;
            if (reg_wr) begin
                ng = reg_wdata[0]; ne = (reg_wdata >> 1) % 8; nf = (reg_wdata >> 4) % 8;
            end
            if (reti_stb) ng = 1;
            if (pick != 0) begin ng = 0; nf = nf & ~pick & 7; end
            if (rdy_pulse || fall) nf = nf | 1;
            if (tick_pulse) nf = nf | 2;
            if (ovf_pulse)  nf = nf | 4;
            m_gie = ng; m_en = ne; m_flg = nf;
            m_call = (pick != 0) ? 1 : 0;
            m_vec  = vec;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model rdata", reg_rdata, m_flg * 16 + m_en * 2 + m_gie);
            chk("R8 model call", call_req, m_call);
            chk("R6 model vec", vec_addr, m_call ? m_vec : 0);
        end
    end

    task automatic tk(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr = 1; reg_wdata = d; tk(1); reg_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        tk(3);
        rst_n = 1;
        tk(1);
        // R1
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 call", call_req, 0);
        chk("R1 vec", vec_addr, 0);
        // R2
        wr(8'h0F); chk("R2 enables", reg_rdata, 'h0F);
        wr(8'hFF); chk("R2 bit7 zero", reg_rdata, 'h7F);
        wr(8'h00); chk("R2 clear", reg_rdata, 0);
        // R3
        rdy_pulse = 1; tk(1); rdy_pulse = 0; chk("R3 data ready", reg_rdata, 'h10);
        tick_pulse = 1; tk(1); tick_pulse = 0; chk("R3 timer", reg_rdata, 'h30);
        ovf_pulse = 1; tk(1); ovf_pulse = 0; chk("R3 counter", reg_rdata, 'h70);
        wr(8'h00);
        // R4
        batt_n = 0; tk(1); chk("R4 fall sets", reg_rdata, 'h10);
        wr(8'h00); tk(3); chk("R4 low level ignored", reg_rdata, 0);
        batt_n = 1; tk(2); chk("R4 rise ignored", reg_rdata, 0);
        // R5
        wr(8'h7E); svc_stb = 1; tk(3); chk("R5 no gie", call_req, 0);
        svc_stb = 0; wr(8'h7F); chk("R5 loaded", reg_rdata, 'h7F);
        tk(2); chk("R5 no strobe", call_req, 0);
        stk_full = 1; svc_stb = 1; tk(2); chk("R5 stack full", call_req, 0);
        chk("R5 flags kept", reg_rdata, 'h7F);
        // R6 R7 R8
        stk_full = 0; tk(1); svc_stb = 0;
        chk("R6 first vector", vec_addr, 'h04);
        chk("R8 call", call_req, 1);
        chk("R7 clear", reg_rdata, 'h6E);
        tk(1); chk("R8 one cycle", call_req, 0); chk("R8 vec idle", vec_addr, 0);
        // R9
        ret_stb = 1; tk(1); ret_stb = 0; chk("R9 ret no effect", reg_rdata, 'h6E);
        reti_stb = 1; tk(1); reti_stb = 0; chk("R9 reti sets", reg_rdata, 'h6F);
        svc_stb = 1; tk(1); svc_stb = 0;
        chk("R6 second vector", vec_addr, 'h08); chk("R7 second", reg_rdata, 'h4E);
        tk(1); reti_stb = 1; tk(1); reti_stb = 0; svc_stb = 1; tk(1); svc_stb = 0;
        chk("R6 third vector", vec_addr, 'h0C); chk("R7 third", reg_rdata, 'h0E);
        tk(1);
        reti_stb = 1; reg_wr = 1; reg_wdata = 8'h0E; tk(1); reti_stb = 0; reg_wr = 0;
        chk("R9 reti over write", reg_rdata, 'h0F);
        wr(8'h0E);
        // R11
        wr(8'h7E); reti_stb = 1; tk(1); reti_stb = 0;
        svc_stb = 1; tk(1); svc_stb = 0; chk("R11 outer call", vec_addr, 'h04);
        wr(8'h6F); chk("R11 gie by write", reg_rdata, 'h6F);
        svc_stb = 1; tk(1); svc_stb = 0;
        chk("R11 nested call", call_req, 1); chk("R11 nested vec", vec_addr, 'h08);
        tk(1);
        // R10
        reg_wr = 1; reg_wdata = 8'h00; tick_pulse = 1; tk(1); reg_wr = 0; tick_pulse = 0;
        chk("R10 set over write", reg_rdata, 'h20);
        wr(8'h25);
        svc_stb = 1; tick_pulse = 1; tk(1); svc_stb = 0; tick_pulse = 0;
        chk("R10 accept", vec_addr, 'h08);
        chk("R10 set over accept", reg_rdata, 'h24);
        tk(3);
        finish_run();
    end
endmodule